// File: doc/BRIEF.md
# Cascadable Two-Bit Arithmetic and Counter Slice Chain

This block is a row of identical two-bit cells joined by a single ripple carry line. Each cell adds, subtracts or compares its two operand bits and passes a carry to the cell above it. Each cell also holds a two-bit count register that steps when the carry reaching it is set. A four-bit mode input gives every cell the same job. The top module sets the carry that enters the lowest cell to suit the selected job, and it presents the carry that leaves the highest cell as `cout`.

In the arithmetic modes the chain produces a sum or a difference. The add/subtract mode takes the direction from `sub_sel` in every cycle. In the counter modes the carry line becomes a ripple enable: the lowest cell sees `cnt_en`, and each cell forwards the enable only when its own bits are at their terminal value. In the compare modes the carry line carries the partial verdict from the low cells to the high cells, so `cout` holds the flag for the full operands. The count register clears asynchronously on `clr` and synchronously on an active-low reset. It loads `load_val` on a clock edge ahead of counting.

Top module: `slice_chain`

## Requirements
- R1: Mode 0 (add): `result` = (a + b) mod 2^W and `cout` is the carry out of the top bit, both combinational.
- R2: Mode 1 (subtract): `result` = (a - b) mod 2^W and `cout` is 1 exactly when a >= b, meaning no borrow.
- R3: Mode 2 (dynamic add/subtract): in the same cycle, `sub_sel` = 1 gives the R2 outputs and `sub_sel` = 0 gives the R1 outputs.
- R4: Mode 3 (up count): on each clock edge with `cnt_en` = 1 the count goes up by 1 and wraps from all ones to zero. `result` shows the count. `cout` = `cnt_en` AND (count is all ones).
- R5: Mode 4 (down count): on each clock edge with `cnt_en` = 1 the count goes down by 1 and wraps from zero to all ones. `cout` = `cnt_en` AND (count is zero).
- R6: Mode 5 (up/down count): `dir_up` = 1 behaves as R4 and `dir_up` = 0 behaves as R5, and the choice can change on any edge.
- R7: While `clr` is high, the count is zero without waiting for a clock edge. `clr` overrides reset, preload and counting.
- R8: In modes 3 to 5, `load` = 1 writes `load_val` into the count on the clock edge and takes priority over counting. With `cnt_en` = 0 and `load` = 0 the count holds its value.
- R9: Mode 6: `cout` = 1 exactly when a >= b, and `result` is zero.
- R10: Mode 7: `cout` = 1 exactly when a != b, and `result` is zero.
- R11: Mode 8: `cout` = 1 exactly when a <= b, and `result` is zero.
- R12: A clock edge with `rst_n` = 0 sets the count to zero. The count holds its value while a non-counter mode is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the count |
| clr | input | 1 | Asynchronous clear of the count, active high |
| mode | input | 4 | Operation select, encoded as in the requirements |
| a | input | W | Operand A, where W = 2 * CELLS |
| b | input | W | Operand B |
| sub_sel | input | 1 | Selects subtraction in mode 2 |
| cnt_en | input | 1 | Count enable, used as the carry into the lowest cell |
| dir_up | input | 1 | Count direction in mode 5 (1 = up) |
| load | input | 1 | Synchronous preload strobe |
| load_val | input | W | Value written by a preload |
| result | output | W | Sum, difference or count; zero in the compare modes |
| cout | output | 1 | Carry, no-borrow, terminal count or compare flag from the top cell |

## Verification
The in-line assertions check the following on every clock cycle: the zero count while `clr` is high, the preload and the hold in each cell, the no-borrow flag in subtraction, the zero result in the compare modes, and the step and terminal flag of the up count. Only the bench scenarios can show the full numeric behaviour of the chain. That covers carries that ripple across all four cells on all-ones operands, wraps in both directions, per-cycle direction changes in the add/subtract and up/down modes, the compare verdicts on equal operands, and the effect of `clr` between clock edges.

// File: rtl/slice_chain_pkg.sv
// Shared types for the slice chain: mode codes, compare kinds and the
// per-cell control word that the top decodes once and fans out to every cell.
package slice_chain_pkg;

    localparam int CELL_BITS = 2;

    typedef enum logic [3:0] {
        MODE_ADD    = 4'd0,
        MODE_SUB    = 4'd1,
        MODE_ADDSUB = 4'd2,
        MODE_UP     = 4'd3,
        MODE_DOWN   = 4'd4,
        MODE_UPDN   = 4'd5,
        MODE_GE     = 4'd6,
        MODE_NE     = 4'd7,
        MODE_LE     = 4'd8
    } op_mode_e;

    typedef enum logic [1:0] {
        CMP_GE = 2'd0,
        CMP_NE = 2'd1,
        CMP_LE = 2'd2
    } cmp_kind_e;

    typedef struct packed {
        logic      is_count;
        logic      is_cmp;
        logic      invert_b;
        logic      count_up;
        cmp_kind_e cmp_kind;
    } cell_ctl_t;

endpackage

// File: rtl/slice_arith.sv
// Combinational two-bit datapath of one cell. It adds a and (possibly
// inverted) b with the incoming carry, or it folds the incoming partial compare
// verdict into its own bits. Assumes the control word stays stable within a cycle.
module slice_arith
    import slice_chain_pkg::*;
(
    input  logic [CELL_BITS-1:0] a,
    input  logic [CELL_BITS-1:0] b,
    input  logic                 ci,
    input  cell_ctl_t            ctl,
    output logic [CELL_BITS-1:0] sum,
    output logic                 co
);

    logic [CELL_BITS-1:0] b_eff;
    logic [CELL_BITS:0]   total;
    logic                 cmp_co;

    // Sum path: a plus optionally inverted b plus the carry in.
    always_comb begin
        b_eff = ctl.invert_b ? ~b : b;
        total = {1'b0, a} + {1'b0, b_eff} + {{CELL_BITS{1'b0}}, ci};
    end

    // Compare path: the local verdict wins unless the bits are equal.
    always_comb begin
        case (ctl.cmp_kind)
            CMP_NE:  cmp_co = (a != b) | ci;
            CMP_LE:  cmp_co = (a < b) | ((a == b) & ci);
            default: cmp_co = (a > b) | ((a == b) & ci);
        endcase
    end

    assign sum = total[CELL_BITS-1:0];
    assign co  = ctl.is_cmp ? cmp_co : total[CELL_BITS];

endmodule

// File: rtl/slice_counter.sv
// Two-bit count register of one cell. It steps when the ripple enable reaches it
// and forwards that enable when its own bits are at the terminal value. Clear is
// asynchronous, reset is synchronous and active-low. Preload outranks counting.
module slice_counter
    import slice_chain_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 is_count,
    input  logic                 up,
    input  logic                 ci,
    input  logic                 load,
    input  logic [CELL_BITS-1:0] load_val,
    output logic [CELL_BITS-1:0] q,
    output logic                 co
);

    // Count state with clear first, then reset, preload and step.
    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            q <= '0;
        end else if (!rst_n) begin
            q <= '0;
        end else if (is_count) begin
            if (load)
                q <= load_val;
            else if (ci)
                q <= up ? q + 1'b1 : q - 1'b1;
        end
    end

    // Ripple enable to the next cell at the terminal value.
    assign co = ci & (up ? (&q) : ~(|q));

    a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> (q == '0))
        else $error("a_r7_clear_zero");

    a_r8_preload: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && is_count && load && !clr) |=> (clr || q == $past(load_val)))
        else $error("a_r8_preload");

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !load && !ci && !clr) |=> (clr || q == $past(q)))
        else $error("a_r8_hold");

endmodule

// File: rtl/arith_cell2.sv
// One two-bit cell: the combinational datapath next to the count register,
// with an output select driven by the shared control word.
module arith_cell2
    import slice_chain_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  cell_ctl_t            ctl,
    input  logic [CELL_BITS-1:0] a,
    input  logic [CELL_BITS-1:0] b,
    input  logic                 ci,
    input  logic                 load,
    input  logic [CELL_BITS-1:0] load_val,
    output logic [CELL_BITS-1:0] res,
    output logic                 co
);

    logic [CELL_BITS-1:0] sum;
    logic [CELL_BITS-1:0] q;
    logic                 arith_co;
    logic                 cnt_co;

    slice_arith u_arith (
        .a   (a),
        .b   (b),
        .ci  (ci),
        .ctl (ctl),
        .sum (sum),
        .co  (arith_co)
    );

    slice_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .is_count (ctl.is_count),
        .up       (ctl.count_up),
        .ci       (ci),
        .load     (load),
        .load_val (load_val),
        .q        (q),
        .co       (cnt_co)
    );

    // Output select: the count, zero for compare, or the sum.
    always_comb begin
        if (ctl.is_count) begin
            res = q;
            co  = cnt_co;
        end else begin
            res = ctl.is_cmp ? '0 : sum;
            co  = arith_co;
        end
    end

endmodule

// File: rtl/slice_chain.sv
// Top: CELLS two-bit cells joined by one ripple carry line. Decodes the mode
// once, sets the carry into the lowest cell and presents the top carry as cout.
// Assumes mode is held steady across the cycles of a count sequence.
module slice_chain
    import slice_chain_pkg::*;
#(
    parameter int CELLS = 4,
    localparam int W = CELLS * CELL_BITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [3:0]   mode,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub_sel,
    input  logic         cnt_en,
    input  logic         dir_up,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] result,
    output logic         cout
);

    cell_ctl_t      ctl;
    logic           seed;
    logic [CELLS:0] carry;

    // Mode decode into the shared control word and the carry seed.
    always_comb begin
        ctl  = '0;
        seed = 1'b0;
        case (op_mode_e'(mode))
            MODE_SUB:    begin ctl.invert_b = 1'b1; seed = 1'b1; end
            MODE_ADDSUB: begin ctl.invert_b = sub_sel; seed = sub_sel; end
            MODE_UP:     begin ctl.is_count = 1'b1; ctl.count_up = 1'b1; seed = cnt_en; end
            MODE_DOWN:   begin ctl.is_count = 1'b1; seed = cnt_en; end
            MODE_UPDN:   begin ctl.is_count = 1'b1; ctl.count_up = dir_up; seed = cnt_en; end
            MODE_GE:     begin ctl.is_cmp = 1'b1; ctl.cmp_kind = CMP_GE; seed = 1'b1; end
            MODE_NE:     begin ctl.is_cmp = 1'b1; ctl.cmp_kind = CMP_NE; end
            MODE_LE:     begin ctl.is_cmp = 1'b1; ctl.cmp_kind = CMP_LE; seed = 1'b1; end
            default:     begin end
        endcase
    end

    assign carry[0] = seed;

    for (genvar i = 0; i < CELLS; i++) begin : g_cell
        arith_cell2 u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (clr),
            .ctl      (ctl),
            .a        (a[i*CELL_BITS +: CELL_BITS]),
            .b        (b[i*CELL_BITS +: CELL_BITS]),
            .ci       (carry[i]),
            .load     (load),
            .load_val (load_val[i*CELL_BITS +: CELL_BITS]),
            .res      (result[i*CELL_BITS +: CELL_BITS]),
            .co       (carry[i+1])
        );
    end

    assign cout = carry[CELLS];

    a_r2_no_borrow: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SUB) |-> (cout == (a >= b)))
        else $error("a_r2_no_borrow");

    a_r9_cmp_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_GE || mode == MODE_NE || mode == MODE_LE) |-> (result == '0))
        else $error("a_r9_cmp_zero");

    a_r4_up_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && mode == MODE_UP && cnt_en && !load && !clr)
        |=> (clr || mode != MODE_UP || result == W'($past(result) + 1'b1)))
        else $error("a_r4_up_step");

    a_r4_terminal: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_UP) |-> (cout == (cnt_en && (&result))))
        else $error("a_r4_terminal");

endmodule

// File: tb/slice_chain_test.sv
// Scoreboard bench: drive() applies one cycle of stimulus at the falling edge
// and queues the expected outputs. The monitor pops and compares them just
// after the next rising edge.
module slice_chain_test;

    localparam int CLK_PERIOD = 10;
    localparam int CELLS = 4;
    localparam int W = CELLS * 2;
    localparam logic [W-1:0] ONES = {W{1'b1}};

    logic         clk = 1'b0;
    logic         rst_n, clr, sub_sel, cnt_en, dir_up, load;
    logic [3:0]   mode;
    logic [W-1:0] a, b, load_val, result;
    logic         cout;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] mcount = '0;

    string        q_tag[$];
    logic [W-1:0] q_res[$];
    logic         q_co[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    slice_chain #(.CELLS(CELLS)) uut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .mode(mode), .a(a), .b(b),
        .sub_sel(sub_sel), .cnt_en(cnt_en), .dir_up(dir_up), .load(load),
        .load_val(load_val), .result(result), .cout(cout)
    );

    task automatic check(input string req, input logic [W-1:0] er, input logic ec);
        checks++;
        if (result !== er || cout !== ec) begin
            errors++;
            $display("FAIL %s: result=%h cout=%b expected result=%h cout=%b",
                     req, result, cout, er, ec);
        end
    endtask

    task automatic drive(input string req, input logic [3:0] m,
                         input logic [W-1:0] av, input logic [W-1:0] bv,
                         input logic s, input logic en, input logic up,
                         input logic ld, input logic [W-1:0] lv);
        logic [W:0]   t;
        logic [W-1:0] er;
        logic         ec;
        logic         goes_up;
        @(negedge clk);
        mode = m; a = av; b = bv; sub_sel = s; cnt_en = en; dir_up = up;
        load = ld; load_val = lv;
        er = '0; ec = 1'b0;
        goes_up = (m == 4'd3) || (m == 4'd5 && up);
        case (m)
            4'd0: begin t = {1'b0, av} + {1'b0, bv}; er = t[W-1:0]; ec = t[W]; end
            4'd1: begin er = av - bv; ec = (av >= bv); end
            4'd2: begin
                if (s) begin er = av - bv; ec = (av >= bv); end
                else begin t = {1'b0, av} + {1'b0, bv}; er = t[W-1:0]; ec = t[W]; end
            end
            4'd3, 4'd4, 4'd5: begin
                if (ld) mcount = lv;
                else if (en) mcount = goes_up ? mcount + 1'b1 : mcount - 1'b1;
                er = mcount;
                ec = en && (goes_up ? (mcount == ONES) : (mcount == '0));
            end
            4'd6: ec = (av >= bv);
            4'd7: ec = (av != bv);
            4'd8: ec = (av <= bv);
            default: ;
        endcase
        q_tag.push_back(req);
        q_res.push_back(er);
        q_co.push_back(ec);
    endtask

    // Monitor: compare queued expectations just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q_res.size() > 0) begin
                string        tg;
                logic [W-1:0] er;
                logic         ec;
                tg = q_tag.pop_front();
                er = q_res.pop_front();
                ec = q_co.pop_front();
                check(tg, er, ec);
            end
        end
    end

    task automatic drain();
        repeat (3) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; clr = 1'b0; mode = 4'd3; a = '0; b = '0; sub_sel = 1'b0;
        cnt_en = 1'b0; dir_up = 1'b0; load = 1'b0; load_val = '0;
        repeat (3) @(negedge clk);
        check("R12 reset state", '0, 1'b0);
        rst_n = 1'b1;

        // R1 add: boundaries then random
        drive("R1 add 0+0", 4'd0, '0, '0, 0, 0, 0, 0, '0);
        drive("R1 add ff+ff", 4'd0, ONES, ONES, 0, 0, 0, 0, '0);
        drive("R1 add ff+1", 4'd0, ONES, 8'd1, 0, 0, 0, 0, '0);
        drive("R1 add equal", 4'd0, 8'h55, 8'h55, 0, 0, 0, 0, '0);
        for (int i = 0; i < 20; i++)
            drive("R1 add random", 4'd0, W'($urandom), W'($urandom), 0, 0, 0, 0, '0);

        // R2 subtract
        drive("R2 sub 0-0", 4'd1, '0, '0, 0, 0, 0, 0, '0);
        drive("R2 sub 0-1", 4'd1, '0, 8'd1, 0, 0, 0, 0, '0);
        drive("R2 sub ff-ff", 4'd1, ONES, ONES, 0, 0, 0, 0, '0);
        drive("R2 sub 0-ff", 4'd1, '0, ONES, 0, 0, 0, 0, '0);
        for (int i = 0; i < 20; i++)
            drive("R2 sub random", 4'd1, W'($urandom), W'($urandom), 0, 0, 0, 0, '0);

        // R3 dynamic add/subtract, direction changing per cycle
        for (int i = 0; i < 20; i++)
            drive("R3 addsub", 4'd2, W'($urandom), W'($urandom), 1'(i % 2), 0, 0, 0, '0);
        drive("R3 addsub sub equal", 4'd2, 8'hA3, 8'hA3, 1, 0, 0, 0, '0);

        // R4 up count through the wrap, then hold (R8)
        drive("R8 preload fd", 4'd3, '0, '0, 0, 0, 0, 1, 8'hFD);
        for (int i = 0; i < 4; i++)
            drive("R4 up count", 4'd3, '0, '0, 0, 1, 0, 0, '0);
        drive("R8 hold en low", 4'd3, '0, '0, 0, 0, 0, 0, '0);
        drive("R8 hold en low", 4'd3, '0, '0, 0, 0, 0, 0, '0);
        drive("R8 preload over count", 4'd3, '0, '0, 0, 1, 0, 1, 8'h3F);
        drive("R4 up ripple 3f", 4'd3, '0, '0, 0, 1, 0, 0, '0);

        // R5 down count through the wrap
        drive("R8 preload 02", 4'd4, '0, '0, 0, 0, 1, 1, 8'h02);
        for (int i = 0; i < 4; i++)
            drive("R5 down count", 4'd4, '0, '0, 0, 1, 1, 0, '0);

        // R6 up/down with direction changing per edge
        drive("R8 preload 80", 4'd5, '0, '0, 0, 0, 0, 1, 8'h80);
        for (int i = 0; i < 16; i++)
            drive("R6 updn", 4'd5, '0, '0, 0, 1'($urandom), 1'($urandom), 0, '0);
        drive("R8 preload ff", 4'd5, '0, '0, 0, 0, 1, 1, ONES);
        drive("R6 updn up wrap", 4'd5, '0, '0, 0, 1, 1, 0, '0);
        drive("R6 updn down wrap", 4'd5, '0, '0, 0, 1, 0, 0, '0);

        // R12 count held in a non-counter mode, seen when counting resumes
        drive("R8 preload 21", 4'd3, '0, '0, 0, 0, 0, 1, 8'h21);
        drive("R12 add leaves count", 4'd0, 8'h10, 8'h01, 0, 1, 0, 1, 8'hEE);
        drive("R12 count kept", 4'd3, '0, '0, 0, 0, 0, 0, '0);

        // R9..R11 compares: boundaries and random
        for (int k = 6; k <= 8; k++) begin
            string tg;
            tg = (k == 6) ? "R9 ge" : (k == 7) ? "R10 ne" : "R11 le";
            drive(tg, 4'(k), '0, '0, 0, 0, 0, 0, '0);
            drive(tg, 4'(k), ONES, ONES, 0, 0, 0, 0, '0);
            drive(tg, 4'(k), ONES, '0, 0, 0, 0, 0, '0);
            drive(tg, 4'(k), '0, ONES, 0, 0, 0, 0, '0);
            drive(tg, 4'(k), 8'h80, 8'h7F, 0, 0, 0, 0, '0);
            drive(tg, 4'(k), 8'h41, 8'h42, 0, 0, 0, 0, '0);
            for (int i = 0; i < 12; i++)
                drive(tg, 4'(k), W'($urandom), W'($urandom), 0, 0, 0, 0, '0);
        end
        drain();

        // R7 asynchronous clear, between edges and against preload
        drive("R8 preload 5a", 4'd3, '0, '0, 0, 0, 0, 1, 8'h5A);
        drain();
        @(negedge clk);
        load = 1'b0; cnt_en = 1'b0;
        #1 clr = 1'b1;
        #1 check("R7 clear without edge", '0, 1'b0);
        load = 1'b1; load_val = 8'hC3; cnt_en = 1'b1;
        @(posedge clk);
        #2 check("R7 clear beats preload", '0, 1'b0);
        @(negedge clk);
        clr = 1'b0; load = 1'b0; cnt_en = 1'b0;
        mcount = '0;
        drive("R7 count after clear", 4'd3, '0, '0, 0, 1, 0, 0, '0);
        drain();

        // R12 synchronous reset mid-run
        drive("R8 preload 77", 4'd3, '0, '0, 0, 0, 0, 1, 8'h77);
        drain();
        @(negedge clk);
        load = 1'b0; cnt_en = 1'b1; rst_n = 1'b0;
        #1 check("R12 reset waits for edge", 8'h77, 1'b0);
        @(posedge clk);
        #2 check("R12 sync reset", '0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1; cnt_en = 1'b0;
        mcount = '0;
        drain();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule